// File: doc/BRIEF.md
# Multi-Group Sample Clock Divider

This block produces one sample-enable strobe for each of sixteen input channels. The channels are arranged as four groups of four. Timing comes from four rate-generator tick inputs and one external tick input. Every tick input is an enable pulse that already lives in the system clock domain, and the block creates no derived clocks.

Each group picks one of the five tick sources. A prescaler per group divides the chosen source by a fixed 128. Each channel then divides the group's prescaled tick by its own integer from 1 to 32 and emits a one-cycle strobe each time its counter wraps.

A group can be realigned by a software sync command or by an external sync pin. A realignment restarts the group's prescaler and all four of its channel counters together, so channels with integer-ratio divisors stay phase-locked. A separate chain tick output repeats a selected source tick, so that a further unit can be driven from the same timing.

Configuration arrives through a single write port. The address map is:

| Address | Content |
|---|---|
| 0 to 15 | 5-bit divisor code of channel A |
| 16 to 19 | 3-bit source code of group A-16 |
| 20 | 3-bit chain output source code |
| 21 | Software sync; data bits 3:0 are a group mask |
| 22 | External sync enable mask, data bits 3:0 |

Channel c belongs to group c/4.

Top module: `sdiv_top`

## Requirements
- R1: A channel with divisor code 1 strobes once per 128 ticks of its group's selected source. The prescale factor is 128.
- R2: A group source code of 0 to 3 selects rate-generator input gen_tick[code]. A code of 4 to 7 selects ext_tick. Ticks on any other input have no effect on that group.
- R3: A divisor code N from 1 to 31 gives one strobe every N prescaled ticks. Code 0 gives one strobe every 32 prescaled ticks.
- R4: Every strobe lasts exactly one clock cycle.
- R5: A new divisor code takes effect only at the channel's next wrap or at the next sync of its group. The count already under way finishes with the old divisor.
- R6: Writing address 21 restarts the prescaler and all four channel counters of every group whose mask bit is set. Groups whose bit is clear are untouched.
- R7: A high level on ext_sync restarts exactly those groups whose bit is set in the mask at address 22.
- R8: chain_tick pulses once for each tick of the source chosen at address 20, using the R2 source encoding. It rises two clock edges after the input tick is sampled.
- R9: After reset the following hold. All strobes and chain_tick are low. Every divisor code is 0, which means divide by 32. Group g uses gen_tick[g]. The chain output uses gen_tick[0]. The external sync mask is 0.
- R10: Strobes occur only on a prescaler wrap. After a sync, a channel dividing by 2 and a channel dividing by 4 in the same group strobe in the same cycle every fourth prescaled tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_tick | input | 4 | Tick enables from the four rate generators |
| ext_tick | input | 1 | Tick enable from the external clock input |
| ext_sync | input | 1 | External group realignment request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| sample_stb | output | 16 | One-cycle sample strobe per channel |
| chain_tick | output | 1 | Repeated source tick for chaining further units |

## Verification
The bound checker watches several properties on every cycle:
- A sync clears its group's prescaler and silences that group's strobes on the next cycle.
- A strobe only ever follows a prescaled group tick and coincides with a freshly wrapped prescaler.
- No strobe lasts longer than one cycle.

Some behaviours can only be shown by the bench scenarios, which count strobes over known tick runs. These are:
- the actual division ratios, including code 0 meaning 32;
- source selection and the isolation of unselected inputs;
- the deferred divisor change;
- the per-group masking of software and external sync;
- phase alignment between channels with integer-ratio divisors;
- the latency of the chain output.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  // Terminal count for a divisor code: code 0 stands for the largest ratio.
  function automatic logic [4:0] div_last(input logic [4:0] code);
    return (code == 5'd0) ? 5'd31 : code - 5'd1;
  endfunction

endpackage

// File: rtl/sdiv_prescale.sv
module sdiv_prescale #(
  parameter int N_SRC    = 5,
  parameter int SEL_W    = 3,
  parameter int PRESCALE = 128,
  localparam int PRE_W   = $clog2(PRESCALE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             sync,
  output logic             grp_tick,
  output logic [PRE_W-1:0] pre_cnt
);

  logic tick;

  // Codes beyond the last internal source all map to the external tick.
  always_comb begin
    if (int'(sel) >= N_SRC - 1) tick = src_tick[N_SRC-1];
    else                        tick = src_tick[sel];
  end

  assign grp_tick = !sync && tick && (pre_cnt == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (rst || sync) pre_cnt <= '0;
    else if (tick)   pre_cnt <= (pre_cnt == PRE_W'(PRESCALE - 1)) ? '0 : pre_cnt + 1'b1;
  end

endmodule

// File: rtl/sdiv_channel.sv
module sdiv_channel
  import sdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       grp_tick,
  input  logic       sync,
  input  logic [4:0] div_code,
  output logic       stb
);

  logic [4:0] cnt;
  logic [4:0] div_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      div_act <= '0;
      stb     <= 1'b0;
    end else if (sync) begin
      cnt     <= '0;
      div_act <= div_code;
      stb     <= 1'b0;
    end else if (grp_tick) begin
      if (cnt == div_last(div_act)) begin
        cnt     <= '0;
        div_act <= div_code;
        stb     <= 1'b1;
      end else begin
        cnt     <= cnt + 5'd1;
        stb     <= 1'b0;
      end
    end else begin
      stb <= 1'b0;
    end
  end

endmodule

// File: rtl/sdiv_top.sv
module sdiv_top #(
  parameter int N_GEN      = 4,
  parameter int N_GRP      = 4,
  parameter int CH_PER_GRP = 4,
  parameter int PRESCALE   = 128,
  parameter int SEL_W      = 3,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  localparam int N_CH      = N_GRP * CH_PER_GRP,
  localparam int N_SRC     = N_GEN + 1,
  localparam int PRE_W     = $clog2(PRESCALE),
  localparam int A_GSEL    = N_CH,
  localparam int A_COUT    = N_CH + N_GRP,
  localparam int A_SYNC    = A_COUT + 1,
  localparam int A_XMSK    = A_COUT + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_GEN-1:0]  gen_tick,
  input  logic              ext_tick,
  input  logic              ext_sync,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_CH-1:0]   sample_stb,
  output logic              chain_tick
);

  logic [N_CH-1:0][4:0]        div_code;
  logic [N_GRP-1:0][SEL_W-1:0] grp_sel;
  logic [SEL_W-1:0]            cout_sel;
  logic [N_GRP-1:0]            xmask;
  logic [N_GRP-1:0]            sw_sync_q;
  logic                        ext_sync_q;
  logic [N_SRC-1:0]            src_q;
  logic [N_GRP-1:0]            grp_sync;
  logic [N_GRP-1:0]            grp_tick;
  logic [N_GRP-1:0][PRE_W-1:0] pre_cnt;

  // Configuration registers and input capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_code   <= '0;
      cout_sel   <= '0;
      xmask      <= '0;
      sw_sync_q  <= '0;
      ext_sync_q <= 1'b0;
      src_q      <= '0;
      for (int g = 0; g < N_GRP; g++)
        grp_sel[g] <= (g < N_GEN) ? SEL_W'(g) : SEL_W'(N_GEN);
    end else begin
      src_q      <= {ext_tick, gen_tick};
      ext_sync_q <= ext_sync;
      sw_sync_q  <= (wr_en && int'(wr_addr) == A_SYNC) ? wr_data[N_GRP-1:0] : '0;
      if (wr_en) begin
        if (int'(wr_addr) < N_CH)
          div_code[wr_addr] <= wr_data[4:0];
        else if (int'(wr_addr) < A_COUT)
          grp_sel[int'(wr_addr) - A_GSEL] <= wr_data[SEL_W-1:0];
        else if (int'(wr_addr) == A_COUT)
          cout_sel <= wr_data[SEL_W-1:0];
        else if (int'(wr_addr) == A_XMSK)
          xmask <= wr_data[N_GRP-1:0];
      end
    end
  end

  assign grp_sync = sw_sync_q | ({N_GRP{ext_sync_q}} & xmask);

  // Chain output repeats the selected captured tick.
  always_ff @(posedge clk) begin
    if (rst)                          chain_tick <= 1'b0;
    else if (int'(cout_sel) >= N_GEN) chain_tick <= src_q[N_GEN];
    else                              chain_tick <= src_q[cout_sel];
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    sdiv_prescale #(
      .N_SRC   (N_SRC),
      .SEL_W   (SEL_W),
      .PRESCALE(PRESCALE)
    ) u_pre (
      .clk     (clk),
      .rst     (rst),
      .src_tick(src_q),
      .sel     (grp_sel[g]),
      .sync    (grp_sync[g]),
      .grp_tick(grp_tick[g]),
      .pre_cnt (pre_cnt[g])
    );
    for (genvar k = 0; k < CH_PER_GRP; k++) begin : g_ch
      sdiv_channel u_ch (
        .clk     (clk),
        .rst     (rst),
        .grp_tick(grp_tick[g]),
        .sync    (grp_sync[g]),
        .div_code(div_code[g*CH_PER_GRP + k]),
        .stb     (sample_stb[g*CH_PER_GRP + k])
      );
    end
  end

endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
  parameter int N_GRP      = 4,
  parameter int CH_PER_GRP = 4,
  parameter int PRESCALE   = 128,
  localparam int N_CH      = N_GRP * CH_PER_GRP,
  localparam int PRE_W     = $clog2(PRESCALE)
) (
  input logic                        clk,
  input logic                        rst,
  input logic [N_GRP-1:0]            grp_sync,
  input logic [N_GRP-1:0]            grp_tick,
  input logic [N_GRP-1:0][PRE_W-1:0] pre_cnt,
  input logic [N_CH-1:0]             stb
);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    a_r6_sync_clears_prescale: assert property (@(posedge clk) disable iff (rst)
      grp_sync[g] |=> pre_cnt[g] == '0);
    a_r6_sync_quiets_group: assert property (@(posedge clk) disable iff (rst)
      grp_sync[g] |=> stb[g*CH_PER_GRP +: CH_PER_GRP] == '0);
    for (genvar k = 0; k < CH_PER_GRP; k++) begin : g_ch
      a_r1_stb_follows_grp_tick: assert property (@(posedge clk) disable iff (rst)
        stb[g*CH_PER_GRP + k] |-> $past(grp_tick[g]));
      a_r10_stb_at_prescale_wrap: assert property (@(posedge clk) disable iff (rst)
        stb[g*CH_PER_GRP + k] |-> pre_cnt[g] == '0);
      if (PRESCALE > 1) begin : g_w
        a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
          stb[g*CH_PER_GRP + k] |=> !stb[g*CH_PER_GRP + k]);
      end
    end
  end

endmodule

bind sdiv_top sdiv_checker #(
  .N_GRP     (N_GRP),
  .CH_PER_GRP(CH_PER_GRP),
  .PRESCALE  (PRESCALE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .grp_sync(grp_sync),
  .grp_tick(grp_tick),
  .pre_cnt (pre_cnt),
  .stb     (sample_stb)
);

// File: tb/sdiv_top_test.sv
module sdiv_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  gen_tick = '0;
  logic        ext_tick = 1'b0;
  logic        ext_sync = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] sample_stb;
  logic        chain_tick;

  int scnt [16];
  int ocnt, both, wide, nchk, nfail;
  logic [15:0] prev_stb;

  always #5 clk = ~clk;

  sdiv_top uut (
    .clk(clk), .rst(rst), .gen_tick(gen_tick), .ext_tick(ext_tick),
    .ext_sync(ext_sync), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_stb(sample_stb), .chain_tick(chain_tick)
  );

  // Table: channel, divisor code, group source code, tick line, ticks, expected strobes
  localparam int NV = 7;
  localparam int V_CH  [NV] = '{0, 5, 10, 15, 7, 12, 2};
  localparam int V_DIV [NV] = '{1, 3, 0, 31, 2, 4, 1};
  localparam int V_SRC [NV] = '{0, 2, 4, 3, 1, 1, 0};
  localparam int V_LINE[NV] = '{0, 2, 4, 3, 1, 1, 3};
  localparam int V_TCK [NV] = '{384, 768, 4096, 3968, 640, 896, 256};
  localparam int V_EXP [NV] = '{3, 2, 1, 1, 2, 1, 0};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  // Called once per falling edge: tally outputs.
  task automatic sample();
    for (int c = 0; c < 16; c++) scnt[c] += int'(sample_stb[c]);
    wide += $countones(sample_stb & prev_stb);
    prev_stb = sample_stb;
    ocnt += int'(chain_tick);
    if (sample_stb[12] && sample_stb[13]) both++;
  endtask

  task automatic clear();
    for (int c = 0; c < 16; c++) scnt[c] = 0;
    ocnt = 0;
    both = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample();
      gen_tick = '0;
      ext_tick = 1'b0;
      wr_en    = 1'b0;
      ext_sync = 1'b0;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    sample();
    wr_en   = 1'b1;
    wr_addr = 5'(a);
    wr_data = 8'(d);
    idle(1);
  endtask

  task automatic sw_sync(input int mask);
    wr(21, mask);
    idle(3);
  endtask

  // Line 0..3 drives gen_tick[line], line 4 drives ext_tick.
  task automatic ticks(input int line, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample();
      gen_tick = '0;
      ext_tick = 1'b0;
      if (line >= 4) ext_tick = 1'b1;
      else           gen_tick[line] = 1'b1;
    end
    idle(4);
  endtask

  initial begin
    #2_000_000;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
    $finish;
  end

  initial begin
    prev_stb = '0;
    wide = 0;
    nchk = 0;
    nfail = 0;
    clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 strobes after reset", int'(sample_stb), 0);
    chk("R9 chain_tick after reset", int'(chain_tick), 0);

    // R9 defaults: divide by 32, group g on gen g, chain on gen 0.
    clear();
    ticks(0, 4096);
    chk("R9 R3 default divide-by-32 ch0", scnt[0], 1);
    chk("R9 group1 default source ch4", scnt[4], 0);
    chk("R9 default chain source count", ocnt, 4096);

    // Table-driven ratio and source tests (R1 R2 R3).
    for (int v = 0; v < NV; v++) begin
      wr(16 + V_CH[v] / 4, V_SRC[v]);
      wr(V_CH[v], V_DIV[v]);
      sw_sync(1 << (V_CH[v] / 4));
      clear();
      ticks(V_LINE[v], V_TCK[v]);
      chk($sformatf("R1 R2 R3 vector %0d", v), scnt[V_CH[v]], V_EXP[v]);
    end
    chk("R4 strobe width", wide, 0);

    // R5: divisor change waits for the wrap.
    wr(16, 0);
    wr(0, 2);
    sw_sync(1);
    clear();
    ticks(0, 128);
    wr(0, 1);
    ticks(0, 256);
    chk("R5 deferred divisor change ch0", scnt[0], 2);

    // R6: software sync restarts only masked groups and the prescaler.
    wr(17, 0);
    wr(0, 4);
    wr(4, 4);
    sw_sync(3);
    clear();
    ticks(0, 256);
    sw_sync(1);
    ticks(0, 256);
    chk("R6 synced group ch0", scnt[0], 0);
    chk("R6 unsynced group ch4", scnt[4], 1);
    wr(0, 1);
    sw_sync(1);
    clear();
    ticks(0, 100);
    sw_sync(1);
    ticks(0, 100);
    chk("R6 prescaler restart ch0", scnt[0], 0);

    // R7: external sync honours its mask.
    wr(18, 0);
    wr(4, 1);
    wr(8, 1);
    wr(22, 2);
    sw_sync(6);
    clear();
    ticks(0, 100);
    @(negedge clk);
    sample();
    ext_sync = 1'b1;
    idle(3);
    ticks(0, 100);
    chk("R7 masked group ch4", scnt[4], 0);
    chk("R7 unmasked group ch8", scnt[8], 1);

    // R10: ratio-2 and ratio-4 channels stay aligned after sync.
    wr(19, 2);
    wr(12, 2);
    wr(13, 4);
    sw_sync(8);
    clear();
    ticks(2, 512);
    chk("R10 ch12 count", scnt[12], 2);
    chk("R10 ch13 count", scnt[13], 1);
    chk("R10 coincident strobes", both, 1);

    // R8: chain output source and latency.
    wr(20, 4);
    idle(2);
    clear();
    for (int i = 0; i < 5; i++) begin
      ticks(4, 1);
      ticks(0, 1);
    end
    chk("R8 chain count on ext", ocnt, 5);
    wr(20, 2);
    idle(2);
    clear();
    ticks(2, 3);
    chk("R8 chain count on gen2", ocnt, 3);
    @(negedge clk);
    sample();
    gen_tick[2] = 1'b1;
    @(negedge clk);
    sample();
    gen_tick = '0;
    chk("R8 chain low after one edge", int'(chain_tick), 0);
    @(negedge clk);
    sample();
    chk("R8 chain high after two edges", int'(chain_tick), 1);
    @(negedge clk);
    sample();
    chk("R8 chain single pulse", int'(chain_tick), 0);
    chk("R4 strobe width final", wide, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule